// File: doc/BRIEF.md
# Serial Converter Readout Controller

This block is the host-side controller for a delta-sigma converter whose only digital link is a read-only two-wire port. The host drives a conversion-start line and a serial clock. The converter answers on one shared line. That line drops low when a result is waiting, and it then carries the result bits. The controller watches the shared line, produces the clock pulses and rebuilds the signed result word. It presents that word to the surrounding logic together with a one-cycle strobe.

The number of clock pulses sent after a word is the only way to command the converter. Twenty-four pulses fetch the word and leave the line at its last bit. Twenty-five pulses fetch the word and then pull the line high, so the next ready indication can be found by polling for a low level. Twenty-six pulses fetch the word and then start a self-calibration. After a calibration the controller waits for the line to drop again and reads the first settled word automatically. It marks that word with a separate flag. Conversions run one at a time, each started by a timed start pulse, or continuously while the start line is held high. Every wait for the ready indication has a limit in system clocks. When the limit runs out, the controller flags a timeout and goes back to idle.

Top module: `adc_reader`

## Requirements
- R1: After reset, start_o, sclk_o, valid_o, timeout_o, cal_word_o and busy_o are all low.
- R2: After a request, the controller drives no sclk_o rising edge while the synchronised line_i is high. The first rising edge follows once the line has been seen low.
- R3: The request code on cmd_i selects the pulse count. 0 gives DATA_W pulses, 1 gives DATA_W+1 pulses, and 2 gives DATA_W+2 pulses followed by a DATA_W+1-pulse read after calibration. 3 gives a single-shot conversion read with DATA_W+1 pulses.
- R4: The word is taken in most-significant-bit first, one bit per pulse for the first DATA_W pulses. It appears on data_o as two's complement, with valid_o high for exactly one cycle.
- R5: Each sclk_o high phase and each low phase inside a burst lasts exactly HALF_CYC system clocks. The line is sampled in the last cycle of each high phase.
- R6: A calibrate request first outputs the current word with cal_word_o low. It then waits up to WAIT_CAL cycles for the line to go low and reads the next word. That word is output with cal_word_o high.
- R7: A single-shot request drives start_o high for exactly START_CYC cycles and then low. The controller then waits for ready and reads the word.
- R8: While cont_i is high, start_o is high, whatever state the controller is in.
- R9: If the line stays high for the wait limit, timeout_o pulses for one cycle and the controller returns to idle. The limit is WAIT_FAST when hires_i=0, WAIT_HIRES when hires_i=1, and WAIT_CAL after a calibration.
- R10: A request made while busy_o is high is ignored and does not change the pulse count of the transaction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, accepted only when idle |
| cmd_i | input | 2 | Request code: 0 read, 1 read with release, 2 calibrate, 3 single shot |
| hires_i | input | 1 | Converter is in high-resolution mode; selects the longer conversion wait |
| cont_i | input | 1 | Hold the start line high for continuous conversion |
| start_o | output | 1 | Conversion start line to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| line_i | input | 1 | Combined ready/data line from the converter |
| data_o | output | DATA_W | Last result word, two's complement |
| valid_o | output | 1 | One-cycle strobe for a new data_o |
| cal_word_o | output | 1 | Word strobed with valid_o is the first one after calibration |
| timeout_o | output | 1 | One-cycle strobe when a ready wait expires |
| busy_o | output | 1 | A transaction is in progress |

## Verification
The hardest case to reach is the second half of a calibration. The bench has to deliver a word, count twenty-six pulses and notice the start of calibration. It then has to raise a fresh ready indication after a delay, or hold it back completely so the calibration wait runs out. A behavioural converter model in the bench counts the rising edges of sclk_o and shifts out the stored word. On the twenty-sixth edge it triggers a delayed ready event, which can be switched off to force the calibration timeout. Around this model, the bench sweeps walking-one words and sign-boundary words through each request code.

// File: rtl/adc_reader_pkg.sv
package adc_reader_pkg;
  typedef enum logic [1:0] {
    CMD_READ    = 2'd0,
    CMD_READ_HI = 2'd1,
    CMD_CAL     = 2'd2,
    CMD_SHOT    = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHOT,
    ST_WAIT,
    ST_CLK,
    ST_CAL_WAIT
  } state_e;
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int HALF_CYC = 10,
  parameter int CNT_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [CNT_W-1:0] npulse_i,
  output logic             sclk_o,
  output logic             sample_o,
  output logic             done_o
);
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [HW-1:0] PH_END = HW'(HALF_CYC - 1);

  logic             active_q, sclk_q;
  logic [HW-1:0]    ph_q;
  logic [CNT_W-1:0] left_q;
  logic             ph_end;

  assign ph_end   = (ph_q == PH_END);
  assign sclk_o   = sclk_q;
  assign sample_o = active_q && sclk_q && ph_end;
  assign done_o   = active_q && !sclk_q && ph_end && (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      ph_q     <= '0;
      left_q   <= '0;
    end else if (!active_q) begin
      if (go_i) begin
        active_q <= 1'b1;
        sclk_q   <= 1'b1;
        ph_q     <= '0;
        left_q   <= npulse_i;
      end
    end else if (ph_end) begin
      ph_q <= '0;
      if (sclk_q) begin
        sclk_q <= 1'b0;
        left_q <= left_q - 1'b1;
      end else if (left_q == '0) begin
        active_q <= 1'b0;
      end else begin
        sclk_q <= 1'b1;
      end
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  p_idle_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !sclk_o);
  p_phase_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= PH_END);
  p_rise_fresh_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> (ph_q == '0));
endmodule

// File: rtl/adc_shift.sv
module adc_shift #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] word_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sr_q;

  assign word_o = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (sample_i && cnt_q < FULL) begin
      sr_q  <= {sr_q[DATA_W-2:0], bit_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
endmodule

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
  parameter int TW = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] limit_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  assign expire_o = (cnt_q == TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= limit_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  p_count_down_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/adc_reader.sv
module adc_reader
  import adc_reader_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int HALF_CYC   = 10,
  parameter int SYNC_N     = 2,
  parameter int START_CYC  = 1800,
  parameter int WAIT_FAST  = 1_330_000,
  parameter int WAIT_HIRES = 8_330_000,
  parameter int WAIT_CAL   = 31_300_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        cmd_i,
  input  logic              hires_i,
  input  logic              cont_i,
  output logic              start_o,
  output logic              sclk_o,
  input  logic              line_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              cal_word_o,
  output logic              timeout_o,
  output logic              busy_o
);
  localparam int CNT_W = $clog2(DATA_W + 3);
  localparam int TM1   = (START_CYC > WAIT_FAST) ? START_CYC : WAIT_FAST;
  localparam int TM2   = (WAIT_HIRES > WAIT_CAL) ? WAIT_HIRES : WAIT_CAL;
  localparam int TMAX  = (TM1 > TM2) ? TM1 : TM2;
  localparam int TW    = $clog2(TMAX + 1);
  localparam logic [CNT_W-1:0] N_PLAIN = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] N_HI    = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] N_CAL   = CNT_W'(DATA_W + 2);
  localparam logic [TW-1:0] L_START = TW'(START_CYC);
  localparam logic [TW-1:0] L_FAST  = TW'(WAIT_FAST);
  localparam logic [TW-1:0] L_HIRES = TW'(WAIT_HIRES);
  localparam logic [TW-1:0] L_CAL   = TW'(WAIT_CAL);

  // line synchroniser, idle level is high
  logic line_s;
  generate
    if (SYNC_N > 1) begin : g_sync
      logic [SYNC_N-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_N-2:0], line_i};
      end
      assign line_s = sync_q[SYNC_N-1];
    end else begin : g_sync1
      logic sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 1'b1;
        else         sync_q <= line_i;
      end
      assign line_s = sync_q;
    end
  endgenerate

  state_e            st_q, st_d;
  logic [CNT_W-1:0]  np_q, np_d;
  logic              calp_q, calp_d, post_q, post_d;
  logic              gen_go, gen_sample, gen_done;
  logic              tmr_load, tmr_exp, shift_clr;
  logic              fire_valid, fire_to;
  logic [TW-1:0]     tmr_lim, conv_lim;
  logic [DATA_W-1:0] word;
  logic              start_q, valid_q, calw_q, to_q;
  logic [DATA_W-1:0] data_q;

  assign conv_lim = hires_i ? L_HIRES : L_FAST;

  always_comb begin
    st_d       = st_q;
    np_d       = np_q;
    calp_d     = calp_q;
    post_d     = post_q;
    gen_go     = 1'b0;
    tmr_load   = 1'b0;
    tmr_lim    = conv_lim;
    shift_clr  = 1'b0;
    fire_valid = 1'b0;
    fire_to    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        tmr_load = 1'b1;
        st_d     = ST_WAIT;
        unique case (cmd_e'(cmd_i))
          CMD_READ:    np_d = N_PLAIN;
          CMD_READ_HI: np_d = N_HI;
          CMD_CAL: begin
            np_d   = N_CAL;
            calp_d = 1'b1;
          end
          CMD_SHOT: begin
            np_d    = N_HI;
            st_d    = ST_SHOT;
            tmr_lim = L_START;
          end
          default: ;
        endcase
      end
      ST_SHOT: if (tmr_exp) begin
        st_d     = ST_WAIT;
        tmr_load = 1'b1;
      end
      ST_WAIT, ST_CAL_WAIT: begin
        if (!line_s) begin
          st_d      = ST_CLK;
          gen_go    = 1'b1;
          shift_clr = 1'b1;
        end else if (tmr_exp) begin
          st_d    = ST_IDLE;
          fire_to = 1'b1;
          calp_d  = 1'b0;
          post_d  = 1'b0;
        end
      end
      ST_CLK: if (gen_done) begin
        fire_valid = 1'b1;
        if (calp_q && !post_q) begin
          st_d     = ST_CAL_WAIT;
          post_d   = 1'b1;
          np_d     = N_HI;
          tmr_load = 1'b1;
          tmr_lim  = L_CAL;
        end else begin
          st_d   = ST_IDLE;
          calp_d = 1'b0;
          post_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      np_q    <= N_HI;
      calp_q  <= 1'b0;
      post_q  <= 1'b0;
      start_q <= 1'b0;
      valid_q <= 1'b0;
      calw_q  <= 1'b0;
      to_q    <= 1'b0;
      data_q  <= '0;
    end else begin
      st_q    <= st_d;
      np_q    <= np_d;
      calp_q  <= calp_d;
      post_q  <= post_d;
      start_q <= cont_i || (st_d == ST_SHOT);
      valid_q <= fire_valid;
      to_q    <= fire_to;
      if (fire_valid) begin
        data_q <= word;
        calw_q <= post_q;
      end
    end
  end

  adc_sclk_gen #(.HALF_CYC(HALF_CYC), .CNT_W(CNT_W)) u_sclk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (gen_go),
    .npulse_i(np_q),
    .sclk_o  (sclk_o),
    .sample_o(gen_sample),
    .done_o  (gen_done)
  );

  adc_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (shift_clr),
    .sample_i(gen_sample),
    .bit_i   (line_s),
    .word_o  (word)
  );

  adc_wait_timer #(.TW(TW)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_load),
    .limit_i (tmr_lim),
    .expire_o(tmr_exp)
  );

  assign start_o    = start_q;
  assign data_o     = data_q;
  assign valid_o    = valid_q;
  assign cal_word_o = calw_q;
  assign timeout_o  = to_q;
  assign busy_o     = (st_q != ST_IDLE);

  p_wait_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT || st_q == ST_CAL_WAIT) |-> !sclk_o);
  p_valid_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_shot_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SHOT) |-> start_o);
  p_cont_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cont_i) |-> start_o);
  p_timeout_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !busy_o);
  p_strobe_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({valid_o, timeout_o}));
  p_ignore_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i && st_q != ST_CLK) |=> $stable(np_q));
endmodule

// File: tb/sim_adc_reader.sv
module sim_adc_reader;
  localparam int DW    = 24;
  localparam int HALF  = 4;
  localparam int SCYC  = 6;
  localparam int WFAST = 200;
  localparam int WHIGH = 400;
  localparam int WCAL  = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, hires = 1'b0, cont = 1'b0, line = 1'b1;
  logic [1:0] cmd = 2'd0;
  logic start_o, sclk_o, valid_o, cal_word_o, timeout_o, busy_o;
  logic [DW-1:0] data_o;

  always #5 clk = ~clk;

  adc_reader #(.DATA_W(DW), .HALF_CYC(HALF), .SYNC_N(2), .START_CYC(SCYC),
               .WAIT_FAST(WFAST), .WAIT_HIRES(WHIGH), .WAIT_CAL(WCAL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cmd_i(cmd), .hires_i(hires),
    .cont_i(cont), .start_o(start_o), .sclk_o(sclk_o), .line_i(line),
    .data_o(data_o), .valid_o(valid_o), .cal_word_o(cal_word_o),
    .timeout_o(timeout_o), .busy_o(busy_o));

  int checks = 0, fails = 0;
  int rises = 0, total = 0;
  logic [DW-1:0] mword = '0, cal_next = '0, shot_word = '0;
  bit cal_hold = 0, auto_conv = 0;
  event cal_ev;

  // converter model
  task automatic make_ready(input logic [DW-1:0] w);
    mword = w; rises = 0; line = 1'b0;
  endtask

  always @(posedge sclk_o) begin
    rises = rises + 1;
    total = total + 1;
    if (rises <= DW) line = mword[DW-rises];
    else line = 1'b1;
    if (rises == DW + 2 && !cal_hold) -> cal_ev;
  end

  initial forever begin
    @(cal_ev);
    repeat (40) @(posedge clk);
    make_ready(cal_next);
  end

  initial forever begin
    @(negedge start_o);
    if (auto_conv) begin
      repeat (30) @(posedge clk);
      make_ready(shot_word);
    end
  end

  // sclk phase monitor
  int run = 0, hp_bad = 0, hi_runs = 0, lo_runs = 0;
  logic prev = 1'b0;
  always @(negedge clk) begin
    if (sclk_o == prev) run++;
    else begin
      if (prev) begin
        hi_runs++;
        if (run != HALF) hp_bad++;
      end else if (rises >= 2 && rises <= DW + 2) begin
        lo_runs++;
        if (run != HALF) hp_bad++;
      end
      run = 1;
    end
    prev = sclk_o;
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c);
    @(negedge clk); req = 1'b1; cmd = c;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic wait_valid(output bit got, output logic [DW-1:0] d, output bit cf);
    got = 0; d = '0; cf = 0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (valid_o) begin got = 1; d = data_o; cf = cal_word_o; end
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && busy_o; i++) @(negedge clk);
  endtask

  function automatic longint sval(input logic [DW-1:0] w);
    return w[DW-1] ? longint'(w) - (longint'(1) << DW) : longint'(w);
  endfunction

  task automatic read_word(input logic [1:0] c, input logic [DW-1:0] w, input int npul, input string rq);
    bit got, cf; logic [DW-1:0] d; int p0;
    make_ready(w);
    p0 = total;
    issue(c);
    wait_valid(got, d, cf);
    chk(got, {rq, " valid strobe"}, got, 1);
    chk(sval(d) == sval(w), "R4 signed word", sval(d), sval(w));
    chk(cf == 0, "R6 flag low on plain read", cf, 0);
    wait_idle();
    chk(total - p0 == npul, {"R3 pulse count ", rq}, total - p0, npul);
  endtask

  task automatic measure_timeout(input int lim, input string rq);
    int n; bit seen;
    n = 0; seen = 0;
    for (int i = 0; i < lim + 50 && !seen; i++) begin
      @(negedge clk); n++;
      if (timeout_o) seen = 1;
    end
    chk(seen && n >= lim && n <= lim + 4, rq, n, lim);
    @(negedge clk);
    chk(!busy_o && !timeout_o, "R9 back to idle, strobe one cycle", busy_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit got, cf; logic [DW-1:0] d; int p0, w;
    repeat (3) @(negedge clk);
    chk({start_o, sclk_o, valid_o, timeout_o, cal_word_o, busy_o} == 6'b0,
        "R1 reset state", {start_o, sclk_o, valid_o, timeout_o, cal_word_o, busy_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 sweep: walking ones and sign boundaries
    for (int b = 0; b < DW; b++) read_word(2'd1, DW'(1) << b, DW + 1, "R4 walk");
    read_word(2'd1, 24'h7FFFFF, DW + 1, "R4 max");
    read_word(2'd1, 24'h800000, DW + 1, "R4 min");
    read_word(2'd1, 24'hFFFFFF, DW + 1, "R4 minus one");
    read_word(2'd1, 24'h000000, DW + 1, "R4 zero");
    read_word(2'd1, 24'hA5C33C, DW + 1, "R4 mixed");
    read_word(2'd0, 24'h5A0F12, DW, "R3 plain");
    read_word(2'd0, 24'h800001, DW, "R3 plain odd");
    chk(hi_runs > 0 && lo_runs > 0 && hp_bad == 0, "R5 half periods", hp_bad, 0);

    // R2: no clock while line high
    line = 1'b1;
    p0 = total;
    issue(2'd1);
    repeat (40) @(negedge clk);
    chk(total == p0 && busy_o, "R2 no sclk before ready", total - p0, 0);
    make_ready(24'h13579B);
    wait_valid(got, d, cf);
    chk(got && d == 24'h13579B, "R2 read after ready", d, 24'h13579B);
    wait_idle();

    // R10: request while busy ignored
    make_ready(24'h2468AC);
    p0 = total;
    issue(2'd1);
    repeat (20) @(negedge clk);
    issue(2'd2);
    wait_valid(got, d, cf);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(total - p0 == DW + 1 && !busy_o && d == 24'h2468AC, "R10 busy request ignored", total - p0, DW + 1);

    // R6: calibration
    cal_next = 24'hC0FFEE;
    make_ready(24'h0BEEF1);
    p0 = total;
    issue(2'd2);
    wait_valid(got, d, cf);
    chk(got && d == 24'h0BEEF1 && cf == 0, "R6 pre-cal word", d, 24'h0BEEF1);
    wait_valid(got, d, cf);
    chk(got && d == 24'hC0FFEE, "R6 post-cal word", d, 24'hC0FFEE);
    chk(cf == 1, "R6 cal flag", cf, 1);
    wait_idle();
    chk(total - p0 == 2 * DW + 3, "R3 R6 cal pulse total", total - p0, 2 * DW + 3);

    // R7: single shot
    auto_conv = 1; shot_word = 24'hFEDCBA;
    line = 1'b1;
    issue(2'd3);
    w = (start_o) ? 1 : 0;
    for (int i = 0; i < 50 && start_o; i++) begin @(negedge clk); if (start_o) w++; end
    chk(w == SCYC, "R7 start width", w, SCYC);
    wait_valid(got, d, cf);
    chk(got && d == 24'hFEDCBA, "R7 shot word", d, 24'hFEDCBA);
    wait_idle();
    auto_conv = 0;

    // R8: continuous
    @(negedge clk); cont = 1'b1;
    repeat (2) @(negedge clk);
    chk(start_o == 1'b1, "R8 start held", start_o, 1);
    make_ready(24'h00F00F);
    issue(2'd1);
    wait_valid(got, d, cf);
    chk(start_o == 1'b1 && d == 24'h00F00F, "R8 start high while reading", start_o, 1);
    wait_idle();
    @(negedge clk); cont = 1'b0;
    repeat (2) @(negedge clk);
    chk(start_o == 1'b0, "R8 start released", start_o, 0);

    // R9: timeouts
    line = 1'b1; hires = 1'b0;
    issue(2'd1);
    measure_timeout(WFAST - 1, "R9 fast timeout");
    hires = 1'b1;
    issue(2'd0);
    measure_timeout(WHIGH - 1, "R9 hires timeout");
    hires = 1'b0;
    cal_hold = 1;
    make_ready(24'h111111);
    issue(2'd2);
    wait_valid(got, d, cf);
    chk(got && d == 24'h111111, "R6 word before held cal", d, 24'h111111);
    measure_timeout(WCAL - 2, "R9 cal timeout");
    cal_hold = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule